// File: doc/BRIEF.md
# Windowed Key-Sequence Watchdog

This block is a watchdog counter that asks for a system reset when software stops servicing it in time. Software services it by writing two key bytes to one service address: first `0x55`, then `0xAA`. The completed pair restarts the count. Any other byte written to that address asks for a reset at once. If the count reaches the selected period before a completed pair arrives, the block also asks for a reset.

The count advances on one of two sources. It can advance on every bus clock cycle, or only on cycles where a 1 kHz tick enable is high. A 2-bit period select picks one of three periods for each source, and the value `00` turns the watchdog off. With the bus clock source, an optional window mode treats any key write made before the last quarter of the period as a fault. The reset request is a one-cycle pulse in the bus clock domain. A reset controller outside this block consumes it. The configuration inputs come from a system options register outside the block, and that register supplies the power-up defaults.

Top module: `wdt_seq_window`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `rst_req` is low.
- R2: Writing `0x55` and then `0xAA` as consecutive service writes sets the count to zero. A block that is serviced this way before each period runs out never raises `rst_req`.
- R3: When the watchdog is enabled, a service write whose data is neither `0x55` nor `0xAA` raises `rst_req` in the cycle after the write.
- R4: If no completed key pair arrives, `rst_req` is raised after exactly one period of count advances, counted from the last restart.
- R5: When `tmo_sel` is `00`, `rst_req` stays low and service writes of any value have no effect.
- R6: When `src_bus` is 0, the count advances only on cycles where `tick_1k` is high. `tmo_sel` values `01`, `10` and `11` select periods of 2^SLOW_E1, 2^SLOW_E2 and 2^SLOW_E3 ticks. The defaults are 32, 256 and 1024.
- R7: When `src_bus` is 1, the count advances on every cycle. `tmo_sel` values `01`, `10` and `11` select 2^BUS_E1, 2^BUS_E2 and 2^BUS_E3 cycles. The defaults are 8192, 65536 and 262144.
- R8: When `src_bus` and `win_en` are both 1, a write of `0x55` or `0xAA` while the count is below three quarters of the period raises `rst_req` in the next cycle. With the defaults, that threshold is 6144, 49152 or 196608.
- R9: In window mode, a key pair whose writes both land at or after the three-quarter point restarts the count without a reset.
- R10: When `src_bus` is 0, `win_en` has no effect, and key writes are accepted at any count.
- R11: A `0xAA` write that does not directly follow a `0x55` service write does not restart the count, and it drops any partial sequence.
- R12: `rst_req` lasts one cycle per event. Every reset event sets the count to zero and clears the partial key sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| svc_wr | input | 1 | Write strobe for the service address |
| svc_data | input | 8 | Data byte of the service write |
| tick_1k | input | 1 | One-cycle enable at 1 kHz, synchronous to `clk` |
| tmo_sel | input | 2 | Period select; `00` disables the watchdog |
| src_bus | input | 1 | 1: count bus cycles, 0: count `tick_1k` pulses |
| win_en | input | 1 | Window mode enable, used only when `src_bus` is 1 |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The assertions assume that `tick_1k` is synchronous to `clk`. They also assume that the configuration inputs change only between cycles. They take no position on how often software writes, so back-to-back faults may produce back-to-back pulses. The stimulus drives every input a short time after a rising edge and holds it for a full cycle. It keeps `tick_1k` as a plain enable and changes the configuration only at quiet points in the directed phases. In the random phase, configuration changes are rare, single-cycle events. The bench shrinks the exponents so that every period and window edge is reached many times.

// File: rtl/wdt_pkg.sv
// Package: shared constants, state type and helpers for the key-sequence watchdog.
// Assumes: period exponents are at least 2 so that a quarter period is whole.
package wdt_pkg;

    localparam int SEL_W  = 2;
    localparam int DATA_W = 8;

    localparam logic [DATA_W-1:0] KEY_OPEN  = 8'h55;
    localparam logic [DATA_W-1:0] KEY_CLOSE = 8'hAA;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_state_t;

    // True for either of the two legal key bytes.
    function automatic logic is_key(input logic [DATA_W-1:0] d);
        return (d == KEY_OPEN) || (d == KEY_CLOSE);
    endfunction

    // Largest of six exponents, used to size the counter.
    function automatic int max6(input int a, input int b, input int c,
                                input int d, input int e, input int f);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        if (f > m) m = f;
        return m;
    endfunction

endpackage

// File: rtl/wdt_limit_sel.sv
// Module: turns the period select and source select into the last count value
// and the window opening count. Purely combinational.
// Assumes: exponents are at least 2 and at most CNT_W.
module wdt_limit_sel
    import wdt_pkg::*;
#(
    parameter int SLOW_E1 = 5,
    parameter int SLOW_E2 = 8,
    parameter int SLOW_E3 = 10,
    parameter int BUS_E1  = 13,
    parameter int BUS_E2  = 16,
    parameter int BUS_E3  = 18,
    parameter int CNT_W   = 18
) (
    input  logic [SEL_W-1:0] tmo_sel,
    input  logic             src_bus,
    output logic             enabled,
    output logic [CNT_W-1:0] last_val,
    output logic [CNT_W-1:0] win_open
);

    localparam int NSEL = 1 << SEL_W;

    logic [CNT_W-1:0] slow_last [NSEL];
    logic [CNT_W-1:0] bus_last  [NSEL];
    logic [CNT_W-1:0] bus_win   [NSEL];

    // Build one table entry per select code; code 0 is the disabled slot.
    for (genvar i = 0; i < NSEL; i++) begin : g_tab
        localparam int SE = (i == 1) ? SLOW_E1 : (i == 2) ? SLOW_E2 : (i == 3) ? SLOW_E3 : 2;
        localparam int BE = (i == 1) ? BUS_E1  : (i == 2) ? BUS_E2  : (i == 3) ? BUS_E3  : 2;
        localparam logic [CNT_W:0] S_PER = (CNT_W+1)'(1) << SE;
        localparam logic [CNT_W:0] B_PER = (CNT_W+1)'(1) << BE;
        localparam logic [CNT_W:0] B_WIN = B_PER - (B_PER >> 2);
        assign slow_last[i] = CNT_W'(S_PER - 1);
        assign bus_last[i]  = CNT_W'(B_PER - 1);
        assign bus_win[i]   = CNT_W'(B_WIN);
    end

    // Select the active entry for the present configuration.
    always_comb begin
        enabled  = (tmo_sel != '0);
        last_val = src_bus ? bus_last[tmo_sel] : slow_last[tmo_sel];
        win_open = bus_win[tmo_sel];
    end

endmodule

// File: rtl/wdt_key_seq.sv
// Module: tracks the two-byte key sequence written to the service address.
// Flags a completed pair and any byte that is not a key. The window check is
// applied outside this module.
// Assumes: clr is raised on every reset event so that a partial pair is dropped.
module wdt_key_seq
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enabled,
    input  logic              clr,
    input  logic              wr,
    input  logic [DATA_W-1:0] data,
    output logic              pair_done,
    output logic              bad_byte,
    output logic              key_wr
);

    seq_state_t state_q;

    // Decode the current write against the tracker state.
    always_comb begin
        key_wr    = enabled && wr && is_key(data);
        bad_byte  = enabled && wr && !is_key(data);
        pair_done = enabled && wr && (data == KEY_CLOSE) && (state_q == SEQ_ARMED);
    end

    // Advance the tracker: only an opening key arms it, and any other write disarms it.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !enabled) begin
            state_q <= SEQ_IDLE;
        end else if (wr) begin
            state_q <= (data == KEY_OPEN) ? SEQ_ARMED : SEQ_IDLE;
        end
    end

endmodule

// File: rtl/wdt_counter.sv
// Module: the watchdog count register. Advances on adv, clears on clear, and
// reports when the count sits at or past the last value of the period.
// Assumes: the caller clears the count on the edge where it is at the last value and advancing.
module wdt_counter #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enabled,
    input  logic             clear,
    input  logic             adv,
    input  logic [CNT_W-1:0] last_val,
    output logic [CNT_W-1:0] cnt,
    output logic             at_last
);

    // Compare against the last value; >= covers a period shortened while counting.
    always_comb at_last = (cnt >= last_val);

    // Hold, clear or step the count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !enabled) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_seq_window.sv
// Module (top): key-sequence watchdog with an optional early-write window.
// Combines the period lookup, the key tracker and the counter, and registers
// a one-cycle reset request on a bad byte, an early key, or a timeout.
// Assumes: tick_1k is a synchronous one-cycle enable; the configuration inputs
// come from a register outside the block that holds its own reset defaults.
module wdt_seq_window
    import wdt_pkg::*;
#(
    parameter int SLOW_E1 = 5,
    parameter int SLOW_E2 = 8,
    parameter int SLOW_E3 = 10,
    parameter int BUS_E1  = 13,
    parameter int BUS_E2  = 16,
    parameter int BUS_E3  = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              svc_wr,
    input  logic [DATA_W-1:0] svc_data,
    input  logic              tick_1k,
    input  logic [SEL_W-1:0]  tmo_sel,
    input  logic              src_bus,
    input  logic              win_en,
    output logic              rst_req
);

    localparam int CNT_W = max6(SLOW_E1, SLOW_E2, SLOW_E3, BUS_E1, BUS_E2, BUS_E3);

    logic             enabled;
    logic [CNT_W-1:0] last_val;
    logic [CNT_W-1:0] win_open;
    logic [CNT_W-1:0] cnt_q;
    logic             at_last;
    logic             pair_done;
    logic             bad_byte;
    logic             key_wr;
    logic             adv;
    logic             early;
    logic             svc_ok;
    logic             timeout;
    logic             fault;
    logic             evt_clear;

    wdt_limit_sel #(
        .SLOW_E1(SLOW_E1), .SLOW_E2(SLOW_E2), .SLOW_E3(SLOW_E3),
        .BUS_E1(BUS_E1),   .BUS_E2(BUS_E2),   .BUS_E3(BUS_E3),
        .CNT_W(CNT_W)
    ) u_limit (
        .tmo_sel (tmo_sel),
        .src_bus (src_bus),
        .enabled (enabled),
        .last_val(last_val),
        .win_open(win_open)
    );

    wdt_key_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .enabled  (enabled),
        .clr      (evt_clear),
        .wr       (svc_wr),
        .data     (svc_data),
        .pair_done(pair_done),
        .bad_byte (bad_byte),
        .key_wr   (key_wr)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .enabled (enabled),
        .clear   (evt_clear),
        .adv     (adv),
        .last_val(last_val),
        .cnt     (cnt_q),
        .at_last (at_last)
    );

    // Combine advance source, window check, service and timeout into events.
    always_comb begin
        adv       = enabled && (src_bus || tick_1k);
        early     = src_bus && win_en && key_wr && (cnt_q < win_open);
        fault     = bad_byte || early;
        svc_ok    = pair_done && !early;
        timeout   = adv && at_last && !svc_ok;
        evt_clear = fault || timeout || svc_ok;
    end

    // Register the reset request so that it is a clean one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
        end else begin
            rst_req <= fault || timeout;
        end
    end

endmodule

// File: rtl/wdt_checker.sv
// Checker: temporal properties of the watchdog, bound into the top module.
// Assumes: the configuration inputs are stable within a cycle.
module wdt_checker #(
    parameter int CNT_W = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             svc_wr,
    input logic [7:0]       svc_data,
    input logic             tick_1k,
    input logic [1:0]       tmo_sel,
    input logic             src_bus,
    input logic             win_en,
    input logic             rst_req,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] win_open,
    input logic             svc_ok
);

    AST_BAD_BYTE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_sel != 2'b00 && svc_wr && svc_data != 8'h55 && svc_data != 8'hAA) |=> rst_req); // R3

    AST_OFF_STAYS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_sel == 2'b00) |=> !rst_req); // R5

    AST_EARLY_KEY_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_sel != 2'b00 && src_bus && win_en && svc_wr && cnt_q < win_open) |=> rst_req); // R8

    AST_TICK_GATES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_sel != 2'b00 && !src_bus && !tick_1k && !svc_wr) |=> $stable(cnt_q)); // R6

    AST_SERVICE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        svc_ok |=> (cnt_q == '0 && !rst_req)); // R2

    AST_EVENT_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (cnt_q == '0)); // R12

endmodule

bind wdt_seq_window wdt_checker #(.CNT_W(CNT_W)) u_wdt_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .svc_wr  (svc_wr),
    .svc_data(svc_data),
    .tick_1k (tick_1k),
    .tmo_sel (tmo_sel),
    .src_bus (src_bus),
    .win_en  (win_en),
    .rst_req (rst_req),
    .cnt_q   (cnt_q),
    .win_open(win_open),
    .svc_ok  (svc_ok)
);

// File: tb/tb_wdt_seq_window.sv
// Bench: directed corner cases followed by seeded random traffic, all compared
// cycle by cycle with a behavioural model written from the requirements.
module tb_wdt_seq_window;

    localparam int SE1 = 2, SE2 = 3, SE3 = 4;
    localparam int BE1 = 4, BE2 = 5, BE3 = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       svc_wr = 1'b0;
    logic [7:0] svc_data = 8'h00;
    logic       tick_1k = 1'b0;
    logic [1:0] tmo_sel = 2'b11;
    logic       src_bus = 1'b0;
    logic       win_en = 1'b0;
    logic       rst_req;

    int total = 0;
    int bad = 0;

    // Model state.
    int  m_cnt = 0;
    bit  m_armed = 0;

    always #4 clk = ~clk;

    wdt_seq_window #(
        .SLOW_E1(SE1), .SLOW_E2(SE2), .SLOW_E3(SE3),
        .BUS_E1(BE1),  .BUS_E2(BE2),  .BUS_E3(BE3)
    ) dut (
        .clk(clk), .rst_n(rst_n), .svc_wr(svc_wr), .svc_data(svc_data),
        .tick_1k(tick_1k), .tmo_sel(tmo_sel), .src_bus(src_bus),
        .win_en(win_en), .rst_req(rst_req)
    );

    function automatic int period(input bit bus, input logic [1:0] sel);
        int e;
        if (bus) e = (sel == 2'd1) ? BE1 : (sel == 2'd2) ? BE2 : BE3;
        else     e = (sel == 2'd1) ? SE1 : (sel == 2'd2) ? SE2 : SE3;
        return 1 << e;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: rst_req actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: apply a write, predict rst_req from the model, compare after the edge.
    task automatic step(input logic we, input logic [7:0] d, input string tag, output logic seen);
        int  lim, opn;
        bit  adv, key, fault, svc, tmo, exp;
        svc_wr   = we;
        svc_data = d;
        exp = 0;
        if (tmo_sel == 2'b00) begin
            m_cnt = 0; m_armed = 0;
        end else begin
            lim   = period(src_bus, tmo_sel);
            opn   = lim - lim / 4;
            adv   = src_bus || tick_1k;
            key   = (d == 8'h55) || (d == 8'hAA);
            fault = we && (!key || (src_bus && win_en && m_cnt < opn));
            svc   = we && d == 8'hAA && m_armed && !fault;
            tmo   = adv && (m_cnt + 1 >= lim) && !svc;
            exp   = fault || tmo;
            if (fault || tmo || svc) begin
                m_cnt = 0; m_armed = 0;
            end else begin
                if (adv) m_cnt++;
                if (we) m_armed = (d == 8'h55);
            end
        end
        @(posedge clk);
        #2;
        check(tag, rst_req, exp);
        seen = rst_req;
        svc_wr = 1'b0;
    endtask

    // Count idle cycles until the next reset pulse, up to a limit.
    task automatic cycles_to_rst(input string tag, input int maxc, input int tick_every, output int n);
        logic s;
        n = 0;
        for (int i = 1; i <= maxc; i++) begin
            tick_1k = (tick_every > 0) && (i % tick_every == 0);
            step(1'b0, 8'h00, tag, s);
            if (s) begin n = i; break; end
        end
        tick_1k = 1'b0;
    endtask

    initial begin : watchdog
        #(8 * 190000);
        bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic s;
        int   n, quiet;
        void'($urandom(32'h5eed_1234));

        // R1: reset holds the request low.
        repeat (3) @(posedge clk);
        #2;
        check("R1", rst_req, 1'b0);
        rst_n = 1'b1;
        step(1'b0, 8'h00, "R1", s);
        check("R1", s, 1'b0);

        // R3 then R7/R4: bus periods counted from the bad-byte restart.
        src_bus = 1'b1;
        tmo_sel = 2'b01;
        step(1'b1, 8'h3C, "R3", s);
        check("R3", s, 1'b1);
        cycles_to_rst("R7", 200, 0, n); check_int("R4", n, 16);
        tmo_sel = 2'b10;
        cycles_to_rst("R7", 200, 0, n); check_int("R7", n, 32);
        tmo_sel = 2'b11;
        cycles_to_rst("R7", 200, 0, n); check_int("R7", n, 64);
        // R12: the pulse lasts one cycle.
        step(1'b0, 8'h00, "R12", s); check("R12", s, 1'b0);

        // R6: slow source counts ticks only, a tick every third cycle.
        src_bus = 1'b0;
        tmo_sel = 2'b01;
        step(1'b1, 8'hFF, "R3", s);
        cycles_to_rst("R6", 400, 3, n); check_int("R6", n, 4 * 3);
        tmo_sel = 2'b11;
        cycles_to_rst("R6", 400, 3, n); check_int("R6", n, 16 * 3);

        // R2: bus, period 16, serviced every 10 cycles.
        src_bus = 1'b1; tmo_sel = 2'b01;
        quiet = 0;
        for (int k = 0; k < 12; k++) begin
            for (int j = 0; j < 8; j++) begin step(1'b0, 8'h00, "R2", s); quiet += s; end
            step(1'b1, 8'h55, "R2", s); quiet += s;
            step(1'b1, 8'hAA, "R2", s); quiet += s;
        end
        check_int("R2", quiet, 0);

        // R11: a lone 0xAA does not restart; timeout lands 16 after the last restart.
        step(1'b1, 8'h01, "R3", s);
        for (int j = 0; j < 4; j++) step(1'b0, 8'h00, "R11", s);
        step(1'b1, 8'hAA, "R11", s);
        cycles_to_rst("R11", 100, 0, n); check_int("R11", n, 16 - 5);
        // R11/R12: 0x55, 0x12 (fault clears), then 0xAA alone.
        step(1'b1, 8'h55, "R11", s);
        step(1'b1, 8'h12, "R12", s); check("R12", s, 1'b1);
        step(1'b1, 8'hAA, "R11", s);
        cycles_to_rst("R11", 100, 0, n); check_int("R11", n, 15);

        // R8: window mode, early key write.
        win_en = 1'b1;
        step(1'b0, 8'h00, "R8", s);
        step(1'b0, 8'h00, "R8", s);
        step(1'b1, 8'h55, "R8", s); check("R8", s, 1'b1);
        // R9: keys at counts 13 and 14 (window opens at 12).
        quiet = 0;
        for (int k = 0; k < 6; k++) begin
            for (int j = 0; j < 13; j++) begin step(1'b0, 8'h00, "R9", s); quiet += s; end
            step(1'b1, 8'h55, "R9", s); quiet += s;
            step(1'b1, 8'hAA, "R9", s); quiet += s;
        end
        check_int("R9", quiet, 0);
        // R8 boundary: key at count 11 is early.
        for (int j = 0; j < 11; j++) step(1'b0, 8'h00, "R8", s);
        step(1'b1, 8'h55, "R8", s); check("R8", s, 1'b1);

        // R10: slow source ignores the window; immediate keys are accepted.
        src_bus = 1'b0; tmo_sel = 2'b01;
        quiet = 0;
        for (int k = 0; k < 20; k++) begin
            tick_1k = 1'b1;
            step(1'b1, 8'h55, "R10", s); quiet += s;
            step(1'b1, 8'hAA, "R10", s); quiet += s;
            tick_1k = 1'b0;
        end
        check_int("R10", quiet, 0);
        win_en = 1'b0;

        // R5: disabled ignores bad bytes and time.
        tmo_sel = 2'b00;
        quiet = 0;
        step(1'b1, 8'h13, "R5", s); quiet += s;
        for (int j = 0; j < 150; j++) begin
            src_bus = j[0];
            tick_1k = 1'b1;
            step(j[1], 8'(j), "R5", s); quiet += s;
        end
        tick_1k = 1'b0;
        check_int("R5", quiet, 0);

        // Random traffic against the model.
        src_bus = 1'b1; tmo_sel = 2'b01;
        for (int i = 0; i < 20000; i++) begin
            int r;
            logic       we;
            logic [7:0] d;
            r = int'($urandom_range(0, 999));
            if (r < 4) begin
                tmo_sel = 2'($urandom_range(0, 3));
                src_bus = 1'($urandom_range(0, 1));
                win_en  = 1'($urandom_range(0, 1));
            end
            tick_1k = ($urandom_range(0, 3) == 0);
            r  = int'($urandom_range(0, 99));
            we = (r < 15);
            r  = int'($urandom_range(0, 99));
            d  = (r < 48) ? 8'h55 : (r < 96) ? 8'hAA : 8'($urandom_range(0, 255));
            step(we, d, "R12", s);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule